// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read

This block buffers words between two unrelated clock domains. The writer pushes words on its own clock, and the reader pops them on a second clock. Both pointers are kept in Gray code and cross to the other side through two-flop synchronizers.

The read behaviour is chosen when the master reset is applied. In standard mode a word is only presented after a read strobe, and the two status outputs act as active-low "full" and "empty" flags. In fall-through mode the oldest word moves into an output register by itself. The same two status outputs then act as "input ready" (low means there is space) and "output ready" (low means the output holds a valid word). The output register adds one word of storage in fall-through mode.

A partial reset empties the FIFO and keeps the selected mode.

Top module: `dcfifo_ft`

## Requirements
- R1: After a master reset with `fwft_sel_i`=0, `full_ir_o`=1 and `empty_or_o`=0. After a master reset with `fwft_sel_i`=1, `full_ir_o`=0 and `empty_or_o`=1.
- R2: In standard mode, with no reads since reset, `full_ir_o` stays 1 after D-1 writes and is 0 once D writes have settled.
- R3: A write presented while `full_ir_o` is at its blocking level is dropped. It changes neither the stored words nor the write pointer.
- R4: In standard mode `empty_or_o` is 0 while no word is held. A read strobe given while empty leaves `rdata_o` and the read pointer unchanged.
- R5: In standard mode words come out in write order. `rdata_o` takes the next word on the read-clock edge that accepts `rd_en_i`.
- R6: In fall-through mode, the first word written into an empty FIFO appears on `rdata_o` with `empty_or_o`=0, without any `rd_en_i`.
- R7: In fall-through mode `full_ir_o` is 0 while space remains. With the first word already in the output register and no reads, it goes to 1 after D+1 writes in total.
- R8: In fall-through mode `empty_or_o` rises only on a read-clock edge with `rd_en_i`=1 when no further word is stored. `rdata_o` keeps the last word, and `rd_en_i` while `empty_or_o`=1 consumes nothing.
- R9: `fwft_sel_i` is sampled only while `rst_ni` is low. A partial reset (`prst_ni` low) discards all stored words and keeps the mode and its flag polarities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, active low, async; mode sampled while low |
| prst_ni | input | 1 | Partial reset, active low, async; pointers only |
| fwft_sel_i | input | 1 | 1 selects fall-through mode, 0 standard mode |
| wr_en_i | input | 1 | Write enable (write clock) |
| wdata_i | input | DATA_W | Write data |
| full_ir_o | output | 1 | Standard: active-low full. Fall-through: high when no space |
| rd_en_i | input | 1 | Read enable (read clock) |
| rdata_o | output | DATA_W | Read data |
| empty_or_o | output | 1 | Standard: active-low empty. Fall-through: low when output word is valid |

## Verification
The hardest state to reach is the fall-through boundary at D+1 words. Reaching it needs one word parked in the output register while the memory behind it is completely full. The stimulus writes a single word and waits until it has crossed both synchronizers and filled the output register. Only then does it write D more words. A sweep over every fill level in both modes then drains the FIFO through that boundary. It also fires blocked writes and blocked reads at the limits and confirms that neither moved a pointer.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
  import fifo_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrst_ni,
  input  logic              fwft_sel_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W:0]   rgray_sync_i,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              wr_accept_o,
  output logic [ADDR_W:0]   wgray_o,
  output logic              flag_o
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  rd_mode_e         mode_q;
  logic [PTR_W-1:0] wbin_q, wbin_nxt, wgray_nxt, full_cmp;
  logic             full_q;

  always_ff @(posedge clk_i) begin
    if (!mrst_ni) mode_q <= fwft_sel_i ? MODE_FWFT : MODE_STD;
  end

  assign wr_accept_o = wr_en_i && !full_q;
  assign wbin_nxt    = wbin_q + {{(PTR_W-1){1'b0}}, wr_accept_o};
  assign wgray_nxt   = wbin_nxt ^ (wbin_nxt >> 1);
  // full when the top two Gray bits differ and the rest match
  assign full_cmp    = {~rgray_sync_i[ADDR_W:ADDR_W-1], rgray_sync_i[ADDR_W-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_o <= '0;
      full_q  <= 1'b0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_o <= wgray_nxt;
      full_q  <= (wgray_nxt == full_cmp);
    end
  end

  assign waddr_o = wbin_q[ADDR_W-1:0];
  assign flag_o  = (mode_q == MODE_FWFT) ? full_q : !full_q;

  function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] occ_w;
  assign occ_w = wbin_q - g2b(rgray_sync_i);

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_w <= DEPTH_P);
  p_blocked_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && wr_en_i) |=> $stable(wbin_q));
  p_gray_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_o ^ $past(wgray_o)) <= 1);
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
  import fifo_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrst_ni,
  input  logic              fwft_sel_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W:0]   wgray_sync_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [ADDR_W:0]   rgray_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              flag_o
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  rd_mode_e         mode_q;
  logic [PTR_W-1:0] rbin_q, rbin_nxt, rgray_nxt;
  logic             empty_q, ov_q, pop;

  always_ff @(posedge clk_i) begin
    if (!mrst_ni) mode_q <= fwft_sel_i ? MODE_FWFT : MODE_STD;
  end

  // fall-through refills the output register whenever it is free or being read
  assign pop = (mode_q == MODE_FWFT) ? (!empty_q && (!ov_q || rd_en_i))
                                     : (rd_en_i && !empty_q);
  assign rbin_nxt  = rbin_q + {{(PTR_W-1){1'b0}}, pop};
  assign rgray_nxt = rbin_nxt ^ (rbin_nxt >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_o <= '0;
      empty_q <= 1'b1;
      ov_q    <= 1'b0;
      rdata_o <= '0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_o <= rgray_nxt;
      empty_q <= (rgray_nxt == wgray_sync_i);
      if (pop) rdata_o <= mem_rdata_i;
      if (mode_q == MODE_FWFT) begin
        if (pop)          ov_q <= 1'b1;
        else if (rd_en_i) ov_q <= 1'b0;
      end else begin
        ov_q <= 1'b0;
      end
    end
  end

  assign raddr_o = rbin_q[ADDR_W-1:0];
  assign flag_o  = (mode_q == MODE_FWFT) ? !ov_q : !empty_q;

  function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] avail_w;
  assign avail_w = g2b(wgray_sync_i) - rbin_q;

  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_w <= DEPTH_P);
  p_std_blocked_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STD && empty_q && rd_en_i) |=> ($stable(rbin_q) && $stable(rdata_o)));
  p_or_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_FWFT && ov_q && rd_en_i && empty_q) |=> (!ov_q && $stable(rdata_o)));
  p_gray_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rgray_o ^ $past(rgray_o)) <= 1);
endmodule

// File: rtl/dcfifo_ft.sv
module dcfifo_ft #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 36
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              prst_ni,
  input  logic              fwft_sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              full_ir_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_or_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;

  logic              rst_all_n;
  logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wr_accept;
  logic [DATA_W-1:0] mem [DEPTH];

  assign rst_all_n = rst_ni & prst_ni;

  always_ff @(posedge wclk_i) begin
    if (wr_accept) mem[waddr] <= wdata_i;
  end

  fifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i        (wclk_i),
    .rst_ni       (rst_all_n),
    .mrst_ni      (rst_ni),
    .fwft_sel_i   (fwft_sel_i),
    .wr_en_i      (wr_en_i),
    .rgray_sync_i (rgray_s),
    .waddr_o      (waddr),
    .wr_accept_o  (wr_accept),
    .wgray_o      (wgray),
    .flag_o       (full_ir_o)
  );

  fifo_gray_sync #(.W(PTR_W)) u_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_all_n),
    .d_i    (rgray),
    .q_o    (rgray_s)
  );

  fifo_gray_sync #(.W(PTR_W)) u_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_all_n),
    .d_i    (wgray),
    .q_o    (wgray_s)
  );

  fifo_rd_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i        (rclk_i),
    .rst_ni       (rst_all_n),
    .mrst_ni      (rst_ni),
    .fwft_sel_i   (fwft_sel_i),
    .rd_en_i      (rd_en_i),
    .wgray_sync_i (wgray_s),
    .mem_rdata_i  (mem[raddr]),
    .raddr_o      (raddr),
    .rgray_o      (rgray),
    .rdata_o      (rdata_o),
    .flag_o       (empty_or_o)
  );
endmodule

// File: tb/dcfifo_ft_tb_top.sv
module dcfifo_ft_tb_top;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 36;
  localparam int D = 1 << ADDR_W;

  logic wclk_i = 1'b0, rclk_i = 1'b0;
  logic rst_ni = 1'b0, prst_ni = 1'b1, fwft_sel_i = 1'b0;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic full_ir_o, empty_or_o;

  int checks = 0, errors = 0;

  always #5 wclk_i = ~wclk_i;  // 100 MHz write clock
  always #7 rclk_i = ~rclk_i;  // unrelated read clock

  dcfifo_ft #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .wclk_i, .rclk_i, .rst_ni, .prst_ni, .fwft_sel_i,
    .wr_en_i, .wdata_i, .full_ir_o, .rd_en_i, .rdata_o, .empty_or_o
  );

  function automatic logic [DATA_W-1:0] pat(int k, int i);
    return {4'ha, 8'(k), 8'(i), 16'h5a0f ^ 16'(k * 7 + i)};
  endfunction

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge rclk_i);
  endtask

  task automatic wr(logic [DATA_W-1:0] d);
    @(negedge wclk_i);
    wr_en_i = 1'b1;
    wdata_i = d;
    @(negedge wclk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd();
    @(negedge rclk_i);
    rd_en_i = 1'b1;
    @(negedge rclk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic mrst(logic mode);
    @(negedge rclk_i);
    rst_ni = 1'b0;
    fwft_sel_i = mode;
    repeat (4) @(negedge rclk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge rclk_i);
  endtask

  initial begin
    #3_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // standard mode
    mrst(1'b0);
    chk("R1 std full", 36'(full_ir_o), 36'(1));
    chk("R1 std empty", 36'(empty_or_o), 36'(0));
    for (int k = 1; k <= D; k++) begin
      for (int i = 0; i < k; i++) wr(pat(k, i));
      settle();
      chk("R4 not empty", 36'(empty_or_o), 36'(1));
      chk("R2 full level", 36'(full_ir_o), 36'(k == D ? 0 : 1));
      if (k == D) begin
        wr(pat(99, 0));
        settle();
        chk("R3 still full", 36'(full_ir_o), 36'(0));
      end
      for (int i = 0; i < k; i++) begin
        rd();
        chk("R5 order", rdata_o, pat(k, i));
      end
      settle();
      chk("R4 empty", 36'(empty_or_o), 36'(0));
      rd();
      chk("R4 blocked read holds", rdata_o, pat(k, k - 1));
      wr(pat(k, 50));
      settle();
      rd();
      chk("R4 pointer unmoved", rdata_o, pat(k, 50));
      settle();
    end

    // fall-through mode
    mrst(1'b1);
    chk("R1 ft ir", 36'(full_ir_o), 36'(0));
    chk("R1 ft or", 36'(empty_or_o), 36'(1));
    for (int k = 1; k <= D + 1; k++) begin
      wr(pat(k, 0));
      settle();
      chk("R6 or low", 36'(empty_or_o), 36'(0));
      chk("R6 word shown", rdata_o, pat(k, 0));
      for (int i = 1; i < k; i++) wr(pat(k, i));
      settle();
      chk("R7 ir level", 36'(full_ir_o), 36'(k == D + 1 ? 1 : 0));
      if (k == D + 1) begin
        wr(pat(99, 1));
        settle();
        chk("R3 ir held", 36'(full_ir_o), 36'(1));
      end
      for (int i = 0; i < k; i++) begin
        chk("R8 or valid", 36'(empty_or_o), 36'(0));
        chk("R8 order", rdata_o, pat(k, i));
        rd();
        repeat (3) @(negedge rclk_i);
      end
      chk("R8 or high", 36'(empty_or_o), 36'(1));
      chk("R8 last kept", rdata_o, pat(k, k - 1));
      rd();
      wr(pat(k, 60));
      settle();
      chk("R8 blocked read", rdata_o, pat(k, 60));
      chk("R8 or after refill", 36'(empty_or_o), 36'(0));
      rd();
      settle();
    end

    // partial reset keeps fall-through mode
    for (int i = 0; i < 3; i++) wr(pat(77, i));
    settle();
    fwft_sel_i = 1'b0;
    prst_ni = 1'b0;
    repeat (4) @(negedge rclk_i);
    prst_ni = 1'b1;
    settle();
    chk("R9 or after prst", 36'(empty_or_o), 36'(1));
    chk("R9 ir after prst", 36'(full_ir_o), 36'(0));
    wr(pat(78, 0));
    settle();
    chk("R9 ft kept", rdata_o, pat(78, 0));
    chk("R9 ft or", 36'(empty_or_o), 36'(0));
    mrst(1'b0);
    chk("R9 std after mrst", 36'(empty_or_o), 36'(0));
    chk("R9 std full", 36'(full_ir_o), 36'(1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule